// File: doc/BRIEF.md
# Transmit Interrupt Coalescer

This block sits between a source of per-frame transmit-complete pulses and one interrupt line, and turns a burst of completions into a smaller number of interrupts. When coalescing is on, the interrupt is raised by whichever limit is hit first. One limit is a frame count: a set number of completed frames since the last interrupt. The other is an elapsed time: a countdown that starts on the first completed frame that asks for an interrupt. When coalescing is off, every completed frame raises the interrupt at once.

The countdown moves once per 64 ticks of a selectable time base. One choice is the system clock, which ticks every cycle. The other is a transmit-interface tick that arrives already synchronized as a one-cycle enable. A single 32-bit configuration word sets the enable, the time base and both limits. The interrupt is a level that stays high until software pulses the acknowledge input.

Top module: `tx_irq_coalescer`

## Requirements
- R1: After reset the interrupt output is low and the configuration word reads back as zero.
- R2: Configuration word layout: bit 31 enables coalescing, bit 30 selects the time base (1 = system clock every cycle, 0 = the alternate tick input), bits 28:21 hold the frame limit and bits 15:0 hold the time limit. Bits 29 and 20:16 ignore writes and read as zero.
- R3: With coalescing off and the interrupt mask set, a frame pulse raises the interrupt at the clock edge that samples it.
- R4: With the mask clear, the interrupt never rises, whatever frame traffic arrives.
- R5: With coalescing on, the interrupt rises at the edge that samples the Nth frame since the last reload, where N is the frame limit. Frames without the request flag never start the countdown.
- R6: The first flagged frame starts the countdown. With the system clock selected, the interrupt rises exactly 64*T cycles after the edge that sampled that frame, where T is the time limit.
- R7: With the alternate time base selected, only pulses on the tick input advance the countdown, and the interrupt rises at the edge that samples the 64*T-th such pulse.
- R8: A zero frame limit or zero time limit acts as 1 while coalescing is on.
- R9: When either limit fires, the frame count reloads and the countdown stops. It stays stopped until a later flagged frame. A frame sampled at the same edge as a firing belongs to that interrupt.
- R10: The interrupt is a level held until the acknowledge pulse. Frames that arrive while it is pending still count toward the next interrupt.
- R11: A configuration write reloads the frame count from the written value and stops the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done_i | input | 1 | One-cycle pulse per transmitted frame |
| frame_irq_req_i | input | 1 | The frame in this cycle asks for an interrupt |
| frame_irq_en_i | input | 1 | Frame interrupt mask; 1 lets the interrupt out |
| alt_tick_i | input | 1 | Synchronized transmit-interface tick enable |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt level |

## Verification
The bench times every interrupt rise to the exact cycle. An off-by-one prescaler, or a countdown that also counts its arming cycle, moves the rise by a cycle or by 64 and is reported. Several cases check that an interrupt stays silent: unflagged frames with a long time limit, a frame limit of 255, a countdown stopped by a firing or by a rewrite, and a time base that is deselected. A design that arms the countdown from any frame, or keeps it armed, fires an interrupt that nothing expected. Zero limits and traffic during a pending interrupt are also covered. A design that takes zero literally hangs, and one that drops frames while the interrupt is pending fires late.

// File: rtl/txc_pkg.sv
package txc_pkg;
   localparam int CFG_W     = 32;
   localparam int EN_BIT    = 31;
   localparam int SRC_BIT   = 30;
   localparam int FTHR_LSB  = 21;
   localparam int FTHR_W    = 8;
   localparam int TTHR_LSB  = 0;
   localparam int TTHR_W    = 16;

   typedef struct packed {
      logic              en;
      logic              src;
      logic [FTHR_W-1:0] fthr;
      logic [TTHR_W-1:0] tthr;
   } txc_cfg_t;

   function automatic txc_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
      txc_cfg_t c;
      c.en   = w[EN_BIT];
      c.src  = w[SRC_BIT];
      c.fthr = w[FTHR_LSB +: FTHR_W];
      c.tthr = w[TTHR_LSB +: TTHR_W];
      return c;
   endfunction

   function automatic logic [CFG_W-1:0] cfg_pack(input txc_cfg_t c);
      logic [CFG_W-1:0] w;
      w = '0;
      w[EN_BIT]               = c.en;
      w[SRC_BIT]              = c.src;
      w[FTHR_LSB +: FTHR_W]   = c.fthr;
      w[TTHR_LSB +: TTHR_W]   = c.tthr;
      return w;
   endfunction
endpackage

// File: rtl/txc_cfg_reg.sv
module txc_cfg_reg
   import txc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CFG_W-1:0]  wdata_i,
   output txc_cfg_t          cfg_o,
   output logic [FTHR_W-1:0] fthr_nxt_o,
   output logic [CFG_W-1:0]  rdata_o
);
   txc_cfg_t cfg_q;
   txc_cfg_t cfg_wr;

   assign cfg_wr = cfg_unpack(wdata_i);

   always_ff @(posedge clk) begin
      if (!rst_n)    cfg_q <= '0;
      else if (wr_i) cfg_q <= cfg_wr;
   end

   // threshold as it will be after this edge, for same-cycle reloads
   assign fthr_nxt_o = wr_i ? cfg_wr.fthr : cfg_q.fthr;
   assign cfg_o      = cfg_q;
   assign rdata_o    = cfg_pack(cfg_q);
endmodule

// File: rtl/txc_frame_ctr.sv
module txc_frame_ctr #(
   parameter int W          = 8,
   parameter bit CLAMP_ZERO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload_i,
   input  logic [W-1:0] thr_i,
   input  logic         count_i,
   output logic         hit_o,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] eff;
   logic [W-1:0] cnt_q;

   generate
      if (CLAMP_ZERO) begin : g_clamp
         assign eff = (thr_i == '0) ? W'(1) : thr_i;
      end else begin : g_raw
         assign eff = thr_i;
      end
   endgenerate

   assign hit_o = count_i && (cnt_q == W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= W'(1);
      else if (reload_i) cnt_q <= eff;
      else if (count_i)  cnt_q <= cnt_q - W'(1);
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/txc_timer.sv
module txc_timer #(
   parameter int W          = 16,
   parameter int PRE_W      = 6,
   parameter bit CLAMP_ZERO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         arm_i,
   input  logic [W-1:0] thr_i,
   input  logic         tick_i,
   output logic         expire_o,
   output logic         armed_o
);
   logic [W-1:0]     eff;
   logic [W-1:0]     cnt_q;
   logic [PRE_W-1:0] pre_q;
   logic             armed_q;
   logic             wrap;

   generate
      if (CLAMP_ZERO) begin : g_clamp
         assign eff = (thr_i == '0) ? W'(1) : thr_i;
      end else begin : g_raw
         assign eff = thr_i;
      end
   endgenerate

   assign wrap     = armed_q && tick_i && (pre_q == '1);
   assign expire_o = wrap && (cnt_q == W'(1));
   assign armed_o  = armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pre_q   <= '0;
         cnt_q   <= '0;
      end else if (clear_i) begin
         armed_q <= 1'b0;
         pre_q   <= '0;
         cnt_q   <= '0;
      end else if (!armed_q) begin
         if (arm_i) begin
            armed_q <= 1'b1;
            pre_q   <= '0;
            cnt_q   <= eff;
         end
      end else if (tick_i) begin
         pre_q <= pre_q + PRE_W'(1);
         if (wrap) cnt_q <= cnt_q - W'(1);
      end
   end
endmodule

// File: rtl/tx_irq_coalescer.sv
module tx_irq_coalescer
   import txc_pkg::*;
#(
   parameter int PRE_W      = 6,
   parameter bit CLAMP_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done_i,
   input  logic              frame_irq_req_i,
   input  logic              frame_irq_en_i,
   input  logic              alt_tick_i,
   input  logic              cfg_wr_i,
   input  logic [CFG_W-1:0]  cfg_wdata_i,
   output logic [CFG_W-1:0]  cfg_rdata_o,
   input  logic              irq_ack_i,
   output logic              irq_o
);
   generate
      if (PRE_W < 1 || PRE_W > 12) begin : g_bad_pre
         $error("PRE_W out of range");
      end
      if (FTHR_LSB + FTHR_W > CFG_W || TTHR_LSB + TTHR_W > CFG_W) begin : g_bad_layout
         $error("configuration fields exceed the word");
      end
   endgenerate

   txc_cfg_t          cfg;
   logic [FTHR_W-1:0] fthr_nxt;
   logic [FTHR_W-1:0] fcnt;
   logic              cnt_hit;
   logic              expire;
   logic              armed;
   logic              tick_sel;
   logic              fire;
   logic              raise;
   logic              reload;
   logic              irq_q;

   txc_cfg_reg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (cfg_wr_i),
      .wdata_i    (cfg_wdata_i),
      .cfg_o      (cfg),
      .fthr_nxt_o (fthr_nxt),
      .rdata_o    (cfg_rdata_o)
   );

   assign tick_sel = cfg.src ? 1'b1 : alt_tick_i;
   assign fire     = cfg.en ? (cnt_hit || expire) : frame_done_i;
   assign raise    = fire && frame_irq_en_i;
   assign reload   = fire || cfg_wr_i || !cfg.en;

   txc_frame_ctr #(.W(FTHR_W), .CLAMP_ZERO(CLAMP_ZERO)) u_fctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload_i (reload),
      .thr_i    (fthr_nxt),
      .count_i  (cfg.en && frame_done_i),
      .hit_o    (cnt_hit),
      .cnt_o    (fcnt)
   );

   txc_timer #(.W(TTHR_W), .PRE_W(PRE_W), .CLAMP_ZERO(CLAMP_ZERO)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (reload),
      .arm_i    (cfg.en && frame_done_i && frame_irq_req_i),
      .thr_i    (cfg.tthr),
      .tick_i   (tick_sel),
      .expire_o (expire),
      .armed_o  (armed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (raise)     irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
   end

   assign irq_o = irq_q;

   logic unused_armed;
   assign unused_armed = armed;
endmodule

// File: rtl/txc_chk.sv
module txc_chk
   import txc_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              frame_done_i,
   input logic              frame_irq_en_i,
   input logic              cfg_wr_i,
   input logic [CFG_W-1:0]  cfg_wdata_i,
   input logic [CFG_W-1:0]  cfg_rdata_o,
   input logic              irq_ack_i,
   input logic              irq_o,
   input logic              raise,
   input logic [FTHR_W-1:0] fcnt
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata_o[29] == 1'b0) && (cfg_rdata_o[20:16] == 5'd0)); // R2

   AST_DIS_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rdata_o[EN_BIT] && frame_done_i && frame_irq_en_i) |=> irq_o); // R3

   AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(frame_irq_en_i)); // R4

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_ack_i) |=> irq_o); // R10

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && !raise) |=> !irq_o); // R10

   AST_FCNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      fcnt != '0); // R8

   AST_WR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_i |=> (fcnt == (($past(cfg_wdata_i[FTHR_LSB +: FTHR_W]) == '0) ?
                     FTHR_W'(1) : $past(cfg_wdata_i[FTHR_LSB +: FTHR_W])))); // R11
endmodule

bind tx_irq_coalescer txc_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .frame_done_i   (frame_done_i),
   .frame_irq_en_i (frame_irq_en_i),
   .cfg_wr_i       (cfg_wr_i),
   .cfg_wdata_i    (cfg_wdata_i),
   .cfg_rdata_o    (cfg_rdata_o),
   .irq_ack_i      (irq_ack_i),
   .irq_o          (irq_o),
   .raise          (raise),
   .fcnt           (fcnt)
);

// File: tb/tx_irq_coalescer_tb_top.sv
module tx_irq_coalescer_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_done_i = 1'b0;
   logic        frame_irq_req_i = 1'b0;
   logic        frame_irq_en_i = 1'b0;
   logic        alt_tick_i = 1'b0;
   logic        cfg_wr_i = 1'b0;
   logic [31:0] cfg_wdata_i = '0;
   logic [31:0] cfg_rdata_o;
   logic        irq_ack_i = 1'b0;
   logic        irq_o;

   int    cyc = 0;
   int    checks = 0;
   int    failures = 0;
   bit    finished = 1'b0;
   bit    irq_prev = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tx_irq_coalescer dut_i (
      .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done_i),
      .frame_irq_req_i(frame_irq_req_i), .frame_irq_en_i(frame_irq_en_i),
      .alt_tick_i(alt_tick_i), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
      .cfg_rdata_o(cfg_rdata_o), .irq_ack_i(irq_ack_i), .irq_o(irq_o)
   );

   function automatic logic [31:0] cfgw(bit en, bit src, int fthr, int tthr);
      return {en, src, 1'b0, 8'(fthr), 5'd0, 16'(tthr)};
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: every interrupt rise must match the next expected cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_o && !irq_prev) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "unexpected interrupt rise", cyc, 0);
            end else begin
               int    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(cyc == e, t, cyc, e);
            end
         end
         irq_prev = irq_o;
      end
   end

   task automatic push_exp(int at, string tag);
      exp_q.push_back(at);
      tag_q.push_back(tag);
   endtask

   // delay < 0: no interrupt expected from this frame
   task automatic frame(bit req, int delay, string tag);
      @(negedge clk);
      frame_done_i = 1'b1;
      frame_irq_req_i = req;
      if (delay >= 0) push_exp(cyc + 1 + delay, tag);
      @(negedge clk);
      frame_done_i = 1'b0;
      frame_irq_req_i = 1'b0;
   endtask

   task automatic tick(bit expect_irq, string tag);
      @(negedge clk);
      alt_tick_i = 1'b1;
      if (expect_irq) push_exp(cyc + 1, tag);
      @(negedge clk);
      alt_tick_i = 1'b0;
   endtask

   task automatic cfg_write(logic [31:0] w);
      @(negedge clk);
      cfg_wr_i = 1'b1;
      cfg_wdata_i = w;
      @(negedge clk);
      cfg_wr_i = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk);
      irq_ack_i = 1'b1;
      @(negedge clk);
      irq_ack_i = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         check(1'b0, "watchdog expired", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(1);
      check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
      check(cfg_rdata_o == 32'h0, "R1 config after reset", cfg_rdata_o, 0);

      // R2: reserved bits
      cfg_write(32'hFFFF_FFFF);
      check(cfg_rdata_o == 32'hDFE0_FFFF, "R2 readback", cfg_rdata_o, 32'hDFE0_FFFF);
      frame(1'b0, -1, "");
      idle(5);
      check(irq_o == 1'b0, "R2 limit 255 not reached", irq_o, 0);
      cfg_write(32'h0);
      check(cfg_rdata_o == 32'h0, "R2 readback zero", cfg_rdata_o, 0);

      // R3 / R10: pass-through and level hold
      frame_irq_en_i = 1'b1;
      frame(1'b0, 0, "R3 pass-through");
      idle(4);
      check(irq_o == 1'b1, "R10 level held", irq_o, 1);
      ack();
      check(irq_o == 1'b0, "R10 ack clears", irq_o, 0);
      frame(1'b1, 0, "R3 flagged pass-through");
      ack();

      // R4: mask
      frame_irq_en_i = 1'b0;
      frame(1'b0, -1, "");
      frame(1'b1, -1, "");
      idle(3);
      check(irq_o == 1'b0, "R4 masked", irq_o, 0);
      frame_irq_en_i = 1'b1;

      // R5: frame limit
      cfg_write(cfgw(1, 1, 3, 100));
      frame(1'b0, -1, "");
      frame(1'b0, -1, "");
      idle(300);
      check(irq_o == 1'b0, "R5 unflagged frames do not start timer", irq_o, 0);
      frame(1'b0, 0, "R5 third frame");
      ack();

      // R6: timer on system clock
      cfg_write(cfgw(1, 1, 10, 2));
      frame(1'b1, 128, "R6 timer expiry at 128 cycles");
      idle(140);
      ack();
      // R9: after firing the timer stays idle
      frame(1'b0, -1, "");
      idle(200);
      check(irq_o == 1'b0, "R9 timer idle after fire", irq_o, 0);

      // R7: alternate time base
      cfg_write(cfgw(1, 0, 10, 1));
      frame(1'b1, -1, "");
      idle(200);
      check(irq_o == 1'b0, "R7 system clock ignored", irq_o, 0);
      for (int i = 0; i < 63; i++) tick(1'b0, "");
      check(irq_o == 1'b0, "R7 63 ticks", irq_o, 0);
      tick(1'b1, "R7 64th tick");
      idle(2);
      ack();

      // R8: zero limits act as 1
      cfg_write(cfgw(1, 1, 0, 0));
      frame(1'b0, 0, "R8 zero frame limit");
      ack();
      frame(1'b1, 0, "R8 zero frame limit flagged");
      ack();
      idle(100);
      check(irq_o == 1'b0, "R9 coincident frame absorbed", irq_o, 0);
      cfg_write(cfgw(1, 1, 5, 0));
      frame(1'b1, 64, "R8 zero time limit");
      idle(70);
      ack();

      // R10: counting while pending
      cfg_write(cfgw(1, 1, 2, 1000));
      frame(1'b0, -1, "");
      frame(1'b0, 0, "R10 first");
      frame(1'b0, -1, "");
      ack();
      frame(1'b0, 0, "R10 counted while pending");
      ack();

      // R11: write reloads counters and stops the timer
      cfg_write(cfgw(1, 1, 3, 1000));
      frame(1'b0, -1, "");
      frame(1'b0, -1, "");
      cfg_write(cfgw(1, 1, 3, 1000));
      frame(1'b0, -1, "");
      frame(1'b0, -1, "");
      idle(5);
      check(irq_o == 1'b0, "R11 count reloaded", irq_o, 0);
      frame(1'b0, 0, "R11 third after write");
      ack();
      cfg_write(cfgw(1, 1, 50, 1));
      frame(1'b1, -1, "");
      idle(10);
      cfg_write(cfgw(1, 1, 50, 1));
      idle(200);
      check(irq_o == 1'b0, "R11 timer stopped by write", irq_o, 0);

      // R9: count fires, timer stops
      cfg_write(cfgw(1, 1, 2, 1));
      frame(1'b1, -1, "");
      frame(1'b0, 0, "R9 count fires first");
      ack();
      idle(150);
      check(irq_o == 1'b0, "R9 timer cleared by count fire", irq_o, 0);

      idle(5);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule